// File: doc/BRIEF.md
# Switchable On-Chip RAM Window

This block places an 8 KB, 16-bit-wide internal RAM behind the CPU-side address decoder of a 24-bit address space. A single enable bit, held at bit 0 of an 8-bit system control register, decides where the fixed window H'FFDC00 to H'FFFBFF goes. With the bit set, CPU accesses that fall in the window are served by the internal RAM. With the bit clear, the same accesses are handed to an external-bus request port. Accesses outside the window always go to that port.

The RAM accepts byte and word reads and writes. Each access takes one bus state with no wait states. Bytes are placed big-endian: an even address uses data bits 15:8 and an odd address uses bits 7:0. Read data appears on the cycle after the request. A byte read is copied onto both lanes, so the CPU can take it from either lane. A word request that arrives with an odd address is aligned down to the even address and raises a one-cycle error pulse.

The control register comes out of reset with the RAM enabled. While the standby input is high the block is frozen: control-register writes and bus requests are ignored. The register therefore holds its value across standby entry and exit.

Top module: `ram_window`

## Requirements
- R1: After reset is released, reg_rdata reads 8'h01: bit 0 (RAM enable) is 1 and bits 7:1 are 0.
- R2: A write with reg_we high and standby low stores all eight bits of reg_wdata. Bits 7:1 read back unchanged and have no effect on routing.
- R3: While standby is high, register writes and bus requests are ignored. The register value, the RAM contents, ext_req, rd_valid and align_err are all unaffected, and the register keeps its value after standby is released.
- R4: If the enable bit is 1 and bus_addr lies in 24'hFFDC00..24'hFFFBFF, the access goes to the internal RAM and ext_req stays low. Any bus request outside the window raises ext_req in the same cycle, with ext_addr, ext_we, ext_word and ext_wdata copied from the bus.
- R5: If the enable bit is 0, a request in the window raises ext_req and leaves the internal RAM unchanged. Contents written earlier can still be read after the bit is set again.
- R6: An internal word access (bus_word=1) writes all 16 bits of bus_wdata. A read returns the word on bus_rdata, with rd_valid high, in the cycle after the request.
- R7: An internal byte write (bus_word=0) at an even address stores bus_wdata[15:8] into bits 15:8 of the word. At an odd address it stores bus_wdata[7:0] into bits 7:0. The other byte of the word is unchanged.
- R8: An internal byte read returns the selected byte on both lanes: {hi,hi} for an even address and {lo,lo} for an odd address.
- R9: An internal word access with bus_addr[0]=1 is performed on the word at the address with bit 0 cleared, writing both bytes. align_err is high for exactly the cycle after the request. It is low after aligned accesses.
- R10: Window edges: 24'hFFDC00 and 24'hFFFBFE are internal, while 24'hFFDBFF and 24'hFFFC00 go external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| standby | input | 1 | Software standby; freezes the block |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| bus_req | input | 1 | CPU access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = word, 0 = byte |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 16 | Write data (big-endian lanes) |
| bus_rdata | output | 16 | Internal read data, one cycle after request |
| rd_valid | output | 1 | bus_rdata holds internal read data |
| align_err | output | 1 | Odd-address word access pulse |
| ext_req | output | 1 | Access forwarded to external bus |
| ext_we | output | 1 | Forwarded write flag |
| ext_word | output | 1 | Forwarded size flag |
| ext_addr | output | 24 | Forwarded address |
| ext_wdata | output | 16 | Forwarded write data |

## Verification
The assertions check several things on every cycle. ext_req only appears for a live, non-standby request. The register never moves in a cycle where standby is high. rd_valid and align_err each follow one cycle after a matching internal request. Which bytes land where, and what a read returns, can only be shown by the bench scenarios. These scenarios cover lane placement of byte writes, byte replication on reads, odd-word alignment and the window edges. They also show that RAM contents survive a period with the enable bit cleared, and that the register keeps its value through a standby episode.

// File: rtl/ram_window.sv
module ram_window #(
  parameter int              ADDR_W    = 24,
  parameter logic [23:0]     WIN_BASE  = 24'hFFDC00,
  parameter logic [23:0]     WIN_LAST  = 24'hFFFBFF,
  parameter logic [7:0]      CTL_RESET = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              rd_valid,
  output logic              align_err,
  output logic              ext_req,
  output logic              ext_we,
  output logic              ext_word,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [15:0]       ext_wdata
);
  localparam int WIN_BYTES = int'(WIN_LAST - WIN_BASE) + 1;
  localparam int WORDS     = WIN_BYTES / 2;
  localparam int IDX_W     = $clog2(WORDS);

  logic [7:0]  ctl_q;
  logic [15:0] mem [WORDS];
  logic [15:0] rdata_q;
  logic        rvalid_q, align_q;

  logic live, in_win, hit, wr_int, rd_int, wr_hi, wr_lo;
  logic [IDX_W-1:0] idx;
  logic [15:0] word_now;

  assign live   = bus_req && !standby;
  assign in_win = (bus_addr >= ADDR_W'(WIN_BASE)) && (bus_addr <= ADDR_W'(WIN_LAST));
  assign hit    = live && ctl_q[0] && in_win;
  assign wr_int = hit && bus_we;
  assign rd_int = hit && !bus_we;
  assign idx    = IDX_W'((bus_addr - ADDR_W'(WIN_BASE)) >> 1);
  assign wr_hi  = wr_int && (bus_word || !bus_addr[0]);
  assign wr_lo  = wr_int && (bus_word ||  bus_addr[0]);
  assign word_now = mem[idx];

  assign ext_req   = live && !hit;
  assign ext_we    = bus_we;
  assign ext_word  = bus_word;
  assign ext_addr  = bus_addr;
  assign ext_wdata = bus_wdata;

  assign reg_rdata = ctl_q;
  assign bus_rdata = rdata_q;
  assign rd_valid  = rvalid_q;
  assign align_err = align_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ctl_q <= CTL_RESET;
    else if (reg_we && !standby) ctl_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (wr_hi) mem[idx][15:8] <= bus_wdata[15:8];
    if (wr_lo) mem[idx][7:0]  <= bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      align_q  <= 1'b0;
    end else begin
      rvalid_q <= rd_int;
      align_q  <= hit && bus_word && bus_addr[0];
      if (rd_int) begin
        if (bus_word)         rdata_q <= word_now;
        else if (bus_addr[0]) rdata_q <= {word_now[7:0], word_now[7:0]};
        else                  rdata_q <= {word_now[15:8], word_now[15:8]};
      end
    end
  end

  // R4
  ext_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> (bus_req && !standby));
  // R3
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> $stable(ctl_q));
  // R3
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (!rd_valid && !align_err));
  // R6
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_req && !bus_we && !standby && ctl_q[0]));
  // R9
  align_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> $past(bus_req && bus_word && bus_addr[0] && !ext_req && !standby));
  // R5
  disabled_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[0] && bus_req && !standby) |=> !rd_valid);
endmodule

// File: tb/tb_ram_window.sv
module tb_ram_window;
  logic clk = 0, rst_n = 0, standby = 0, reg_we = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic bus_req = 0, bus_we = 0, bus_word = 0;
  logic [23:0] bus_addr = 0, ext_addr;
  logic [15:0] bus_wdata = 0, bus_rdata, ext_wdata;
  logic rd_valid, align_err, ext_req, ext_we, ext_word;
  int checks = 0, failures = 0;
  logic s_ext, s_rv, s_al;
  logic [15:0] s_rd;
  logic [23:0] s_ea;

  always #4 clk = ~clk;

  ram_window dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(logic we, logic word, logic [23:0] a, logic [15:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_word = word; bus_addr = a; bus_wdata = d;
    #1 s_ext = ext_req; s_ea = ext_addr;
    @(posedge clk); #1;
    s_rv = rd_valid; s_rd = bus_rdata; s_al = align_err;
    @(negedge clk) bus_req = 0;
  endtask

  task automatic wreg(logic [7:0] v);
    @(negedge clk) reg_we = 1; reg_wdata = v;
    @(negedge clk) reg_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset value", reg_rdata, 8'h01);
  endtask

  task automatic t_word;
    acc(1, 1, 24'hFFDC00, 16'h1234);
    chk("R4 internal no ext_req", s_ext, 0);
    chk("R9 no align_err aligned", s_al, 0);
    acc(0, 1, 24'hFFDC00, 0);
    chk("R6 rd_valid", s_rv, 1);
    chk("R6 word read", s_rd, 16'h1234);
    acc(1, 1, 24'hFFFBFE, 16'hA5C3);
    chk("R10 top word internal", s_ext, 0);
    acc(0, 1, 24'hFFFBFE, 0);
    chk("R10 top word read", s_rd, 16'hA5C3);
  endtask

  task automatic t_byte;
    acc(1, 1, 24'hFFE000, 16'h0000);
    acc(1, 0, 24'hFFE000, 16'hAB77);
    acc(0, 1, 24'hFFE000, 0);
    chk("R7 even byte upper lane", s_rd, 16'hAB00);
    acc(1, 0, 24'hFFE001, 16'h88CD);
    acc(0, 1, 24'hFFE000, 0);
    chk("R7 odd byte lower lane", s_rd, 16'hABCD);
    acc(0, 0, 24'hFFE000, 0);
    chk("R8 even byte read", s_rd, 16'hABAB);
    acc(0, 0, 24'hFFE001, 0);
    chk("R8 odd byte read", s_rd, 16'hCDCD);
    chk("R8 rd_valid", s_rv, 1);
  endtask

  task automatic t_align;
    acc(1, 1, 24'hFFE003, 16'h5566);
    chk("R9 align_err pulse", s_al, 1);
    @(posedge clk); #1;
    chk("R9 align_err one cycle", align_err, 0);
    acc(0, 1, 24'hFFE002, 0);
    chk("R9 aligned word written", s_rd, 16'h5566);
    chk("R9 no align_err after aligned", s_al, 0);
  endtask

  task automatic t_bound;
    acc(0, 0, 24'hFFDBFF, 0);
    chk("R10 below window external", s_ext, 1);
    chk("R4 ext_addr copy", s_ea, 24'hFFDBFF);
    chk("R10 below window no rd_valid", s_rv, 0);
    acc(0, 0, 24'hFFFC00, 0);
    chk("R10 above window external", s_ext, 1);
    acc(1, 1, 24'h000100, 16'h4242);
    chk("R4 far address external", s_ext, 1);
  endtask

  task automatic t_disable;
    wreg(8'h00);
    chk("R2 write zero", reg_rdata, 8'h00);
    acc(1, 1, 24'hFFDC00, 16'h9999);
    chk("R5 disabled window external", s_ext, 1);
    acc(0, 1, 24'hFFDC00, 0);
    chk("R5 disabled read no rd_valid", s_rv, 0);
    wreg(8'hFF);
    chk("R2 all bits readback", reg_rdata, 8'hFF);
    acc(0, 1, 24'hFFDC00, 0);
    chk("R2 upper bits no routing effect", s_ext, 0);
    chk("R5 ram unchanged while disabled", s_rd, 16'h1234);
  endtask

  task automatic t_standby;
    wreg(8'h81);
    @(negedge clk) standby = 1;
    wreg(8'h00);
    chk("R3 write ignored in standby", reg_rdata, 8'h81);
    acc(1, 1, 24'hFFDC00, 16'hDEAD);
    chk("R3 no ext_req in standby", s_ext, 0);
    chk("R3 no rd_valid in standby", s_rv, 0);
    @(negedge clk) standby = 0;
    @(negedge clk);
    chk("R3 value kept after standby", reg_rdata, 8'h81);
    acc(0, 1, 24'hFFDC00, 0);
    chk("R3 ram untouched in standby", s_rd, 16'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_word; t_byte; t_align; t_bound; t_disable; t_standby;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule